// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a machine whose instructions are all one 32-bit word long. On every enabled clock edge it picks the next PC from one of three sources. The first is the sequential address (PC+4). The second is a PC-relative branch target, taken when a register comparison succeeds. The third is a region-absolute jump target. It decodes only the 6-bit opcode in the top bits of the current instruction word. It compares the two register operand values that the surrounding datapath has already read for the rs and rt fields.

Branch offsets count instructions, not bytes. The offset is sign-extended, scaled by four and added to the address of the following instruction. A jump replaces the low 28 address bits with its 26-bit index followed by two zero bits. The top four bits of the current PC are kept, so a jump never leaves its 256 MB region. All arithmetic wraps modulo 2^32. The block drives both the current PC and PC+4, so the fetch stage and a link path can use them.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC loads the parameter `RESET_VEC` (default 0). This happens whatever the value of `en`.
- R2: When `rst_n` is high and `en` is low at a rising edge, the PC keeps its value, whatever the instruction and operands are.
- R3: For any opcode (instr[31:26]) other than 2, 4 or 5, an enabled edge loads PC+4, wrapping from 0xFFFFFFFC to 0.
- R4: For opcode 4, if `rs_val` equals `rt_val`, an enabled edge loads PC+4 plus the sign-extended instr[15:0] multiplied by 4.
- R5: For opcode 5, if `rs_val` differs from `rt_val`, an enabled edge loads the same PC-relative target as R4.
- R6: A branch whose condition fails (opcode 4 with unequal operands, or opcode 5 with equal operands) loads PC+4.
- R7: For opcode 2, an enabled edge loads {PC[31:28], instr[25:0], 2'b00}.
- R8: `pc_plus4` always equals `pc` + 4, modulo 2^32.
- R9: Bits 1:0 of `pc` are always zero after reset.
- R10: The branch offsets 0x7FFF (+32767 words) and 0x8000 (-32768 words) reach their targets exactly. A target below address 0 wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Update enable for the PC |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | Register value selected by instr[25:21] |
| rt_val | input | 32 | Register value selected by instr[20:16] |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Address of the following instruction |

## Verification
On every cycle, assertions check four things: that reset loads the vector, that a disabled edge holds the PC, that sequential and failed-branch edges advance by exactly one word, and that a jump keeps the top four PC bits. Word alignment of the PC is also checked on every cycle. The exact branch arithmetic cannot be seen by those properties. This covers sign extension at the offset extremes and the wrap below zero. The exact jump target is also outside them. Only the bench's reference model shows these, by comparing every cycle under directed and random instruction streams.

// File: rtl/npc_pkg.sv
// Shared definitions for the next-PC unit: opcode values and the
// next-address selector. Assumes a 6-bit opcode in the top instruction bits.
package npc_pkg;
    localparam int unsigned OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BR_NE = 6'd5;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_BRANCH = 2'd1,
        NXT_JUMP   = 2'd2
    } nxt_kind_e;
endpackage

// File: rtl/npc_decode.sv
// Opcode classifier and branch condition evaluator.
// Assumes: opcode in the top OPC_W bits of the instruction word; operand
// values were already read for the rs and rt fields by the datapath.
module npc_decode
    import npc_pkg::*;
#(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output nxt_kind_e          kind,
    output logic               take
);
    localparam int unsigned OPC_LO = INSTR_W - OPC_W;

    logic [OPC_W-1:0]  opcode;
    logic [DATA_W-1:0] diff_bits;
    logic              operands_eq;

    assign opcode = instr[INSTR_W-1:OPC_LO];

    // Per-bit mismatch vector, built bit by bit so the equality is a flat OR tree.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_cmp
        assign diff_bits[gi] = opa[gi] ^ opb[gi];
    end

    // Equality of the two operand values.
    always_comb begin
        operands_eq = (diff_bits == '0);
    end

    // Classify opcode and resolve the branch condition.
    always_comb begin
        kind = NXT_SEQ;
        take = 1'b0;
        unique case (opcode)
            OPC_BR_EQ: begin
                kind = NXT_BRANCH;
                take = operands_eq;
            end
            OPC_BR_NE: begin
                kind = NXT_BRANCH;
                take = !operands_eq;
            end
            OPC_JUMP: begin
                kind = NXT_JUMP;
                take = 1'b1;
            end
            default: begin
                kind = NXT_SEQ;
                take = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/npc_target.sv
// Target address generator: sequential, PC-relative and region-absolute.
// Assumes: word-aligned PC, a word-count immediate of IMM_W bits in the low
// instruction bits, and a jump index of JIDX_W bits in the low instruction bits.
module npc_target
    import npc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned JIDX_W  = 26
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic [INSTR_W-1:0] instr,
    input  nxt_kind_e          kind,
    input  logic               take,
    output logic [ADDR_W-1:0]  pc_plus4,
    output logic [ADDR_W-1:0]  pc_next
);
    localparam int unsigned REGION_W = ADDR_W - JIDX_W - 2;
    localparam int unsigned SEXT_W   = ADDR_W - IMM_W - 2;
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    logic [IMM_W-1:0]  imm;
    logic [ADDR_W-1:0] byte_off;
    logic [ADDR_W-1:0] br_target;
    logic [ADDR_W-1:0] jmp_target;

    assign imm = instr[IMM_W-1:0];

    // Sequential address; the carry out of the top bit is dropped.
    always_comb begin
        pc_plus4 = pc + WORD_BYTES;
    end

    // Word offset, sign-extended and scaled to bytes, added to PC+4.
    always_comb begin
        byte_off  = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_target = pc_plus4 + byte_off;
    end

    // Jump keeps the current region bits and replaces the rest.
    always_comb begin
        jmp_target = {pc[ADDR_W-1 -: REGION_W], instr[JIDX_W-1:0], 2'b00};
    end

    // Final selection of the next address.
    always_comb begin
        pc_next = pc_plus4;
        if (kind == NXT_BRANCH && take) begin
            pc_next = br_target;
        end else if (kind == NXT_JUMP) begin
            pc_next = jmp_target;
        end
    end
endmodule

// File: rtl/npc_unit.sv
// Next program counter unit: holds the PC and advances it each enabled cycle.
// Assumes: RESET_VEC is word-aligned; the instruction word and operand values
// for the current PC are presented in the same cycle.
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic [31:0] pc_plus4
);
    localparam int unsigned INSTR_W = 32;

    nxt_kind_e         kind;
    logic              take;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] pc_inc;

    npc_decode #(
        .INSTR_W (INSTR_W),
        .DATA_W  (32)
    ) u_decode (
        .instr (instr),
        .opa   (rs_val),
        .opb   (rt_val),
        .kind  (kind),
        .take  (take)
    );

    npc_target #(
        .ADDR_W  (ADDR_W),
        .INSTR_W (INSTR_W),
        .IMM_W   (16),
        .JIDX_W  (26)
    ) u_target (
        .pc       (pc_q),
        .instr    (instr),
        .kind     (kind),
        .take     (take),
        .pc_plus4 (pc_inc),
        .pc_next  (pc_next)
    );

    // PC register: synchronous reset to the vector, load only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_VEC;
        end else if (en) begin
            pc_q <= pc_next;
        end
    end

    assign pc       = pc_q;
    assign pc_plus4 = pc_inc;

    AST_RESET_LOAD: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_VEC);                                   // R1
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pc));                                           // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == NXT_SEQ) |=> pc == $past(pc_plus4));             // R3
    AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == NXT_BRANCH && !take) |=> pc == $past(pc_plus4)); // R6
    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kind == NXT_JUMP) |=> pc[31:28] == $past(pc[31:28]));    // R7
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc[1:0] == 2'b00);                             // R9
endmodule

// File: tb/sim_npc_unit.sv
// Bench for npc_unit: behavioural next-PC model compared on every clock.
module sim_npc_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] RV = 32'hFFFF_FFF4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc;
    logic [31:0] pc_plus4;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] exp_pc = '0;
    bit          model_ok = 1'b0;
    string       last_req = "R1";
    bit          finished = 1'b0;

    npc_unit #(.RESET_VEC(RV)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .pc_plus4(pc_plus4)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: computes the expected PC from the requirement text.
    always @(posedge clk) begin
        int          op;
        int          off;
        logic [31:0] p4;
        op = int'(instr[31:26]);
        p4 = exp_pc + 32'd4;
        off = int'($signed(instr[15:0])) * 4;
        if (!rst_n) begin
            exp_pc = RV; last_req = "R1"; model_ok = 1'b1;
        end else if (!en) begin
            last_req = "R2";
        end else if (op == 4) begin
            if (rs_val == rt_val) begin exp_pc = p4 + 32'(off); last_req = "R4/R10"; end
            else begin exp_pc = p4; last_req = "R6"; end
        end else if (op == 5) begin
            if (rs_val != rt_val) begin exp_pc = p4 + 32'(off); last_req = "R5/R10"; end
            else begin exp_pc = p4; last_req = "R6"; end
        end else if (op == 2) begin
            exp_pc = (exp_pc & 32'hF000_0000) | (instr[25:0] * 32'd4);
            last_req = "R7";
        end else begin
            exp_pc = p4; last_req = "R3";
        end
    end

    // Comparison away from the active edge.
    always @(negedge clk) begin
        if (model_ok && !finished) begin
            n_vec++;
            if (pc !== exp_pc) begin
                n_bad++;
                $display("FAIL %s pc actual=%h expected=%h", last_req, pc, exp_pc);
            end
            n_vec++;
            if (pc_plus4 !== exp_pc + 32'd4) begin
                n_bad++;
                $display("FAIL R8 pc_plus4 actual=%h expected=%h", pc_plus4, exp_pc + 32'd4);
            end
            n_vec++;
            if (pc[1:0] !== 2'b00) begin
                n_bad++;
                $display("FAIL R9 pc low bits actual=%b expected=00", pc[1:0]);
            end
        end
    end

    task automatic drive(input logic r, input logic e, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        #1;
        rst_n = r; en = e; instr = ins; rs_val = a; rt_val = b;
    endtask

    function automatic logic [31:0] mk_br(input int op, input logic [15:0] imm);
        return {6'(op), 5'd9, 5'd0, imm};
    endfunction

    initial begin
        // R1: reset with enable low still loads the vector
        drive(0, 0, 32'h0800_0010, 0, 0);
        drive(0, 1, 32'h0000_0000, 0, 0);
        // R3: sequential steps wrap through 0xFFFFFFFC to 0
        drive(1, 1, 32'h012A_4020, 1, 2);
        drive(1, 1, 32'h0009_4100, 3, 3);
        drive(1, 1, 32'h22D5_FFCE, 0, 0);
        drive(1, 1, 32'h8D09_000C, 0, 0);
        // R2: disabled edges with a jump and a taken branch present
        drive(1, 0, 32'h0800_1234, 0, 0);
        drive(1, 0, mk_br(4, 16'h0100), 7, 7);
        // R4: equal branch taken, forward
        drive(1, 1, mk_br(4, 16'd3), 5, 5);
        // R6: equal branch not taken
        drive(1, 1, mk_br(4, 16'd3), 5, 6);
        // R5: not-equal branch taken, backward
        drive(1, 1, mk_br(5, 16'hFFFE), 1, 2);
        // R6: not-equal branch not taken
        drive(1, 1, mk_br(5, 16'h0040), 9, 9);
        // R7: jump within the region
        drive(1, 1, 32'h0BFF_FFFF, 0, 0);
        drive(1, 1, 32'h0800_0100, 0, 0);
        // R10: offset extremes and wrap below zero
        drive(1, 1, mk_br(4, 16'h7FFF), 0, 0);
        drive(1, 1, mk_br(4, 16'h8000), 0, 0);
        drive(1, 1, mk_br(4, 16'h8000), 0, 0);
        drive(1, 1, 32'h0800_0001, 0, 0);
        drive(1, 1, mk_br(5, 16'h8000), 1, 0);
        // Random mix of all classes, with occasional hold and reset
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            logic [31:0] a;
            logic [31:0] b;
            int sel;
            w = $urandom;
            sel = $urandom_range(0, 5);
            if (sel == 0) w[31:26] = 6'd2;
            else if (sel == 1) w[31:26] = 6'd4;
            else if (sel == 2) w[31:26] = 6'd5;
            a = $urandom_range(0, 3);
            b = $urandom_range(0, 3);
            drive(($urandom_range(0, 49) != 0), ($urandom_range(0, 7) != 0), w, a, b);
        end
        drive(1, 1, 32'h0000_0000, 0, 0);
        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule